// File: doc/BRIEF.md
# Self-Timed Refresh Sequencer for a Pseudo-Static Memory

This block holds the refresh logic that a pseudo-static memory keeps on the chip. A single active-low refresh strobe drives two modes, and the length of the low pulse picks the mode. A short pulse runs one auto-refresh of the row held in an internal row counter. A long hold enters self refresh, in which a free-running timer schedules row refreshes until the strobe goes high again. A falling chip enable starts a chip-enable-only refresh of the row given on the external row address. A multiplexer picks which row address goes out with each refresh pulse.

Guard times are counted in clock cycles and set by parameters. The strobe must stay low for a minimum time before a pulse counts. It must stay high for a recovery time before the next pulse is accepted. After self refresh ends, a lockout window flags any early chip enable. A strobe-driven refresh starts only after chip enable has been inactive for a minimum time. A request that arrives sooner waits and is not lost. All inputs are synchronous to `clk`.

Top module: `psram_refresh_seq`

## Requirements
- R1: During and right after reset, `row_addr` is 0 and `row_pulse`, `busy` and `ce_early` are low. The internal row counter starts at 0.
- R2: A strobe low for at least MIN_PULSE and fewer than SELF_ENTRY consecutive clock samples gives exactly one `row_pulse`. That pulse carries the current counter value on `row_addr`, and the counter then advances by one.
- R3: A strobe low for fewer than MIN_PULSE samples gives no `row_pulse` and leaves the counter unchanged.
- R4: A strobe low for SELF_ENTRY samples or more enters self refresh. One refresh is issued on entry and one more after every SELF_PERIOD cycles spent in self refresh, each at the next counter value. `busy` stays high throughout.
- R5: After an auto-refresh pulse, the strobe must be high for RECOV_HIGH consecutive samples. A low strobe before then gives no refresh, and it restarts the high count. A low that arrives right after RECOV_HIGH high samples is accepted.
- R6: When the strobe rises out of self refresh, a lockout of CE_LOCKOUT cycles begins, and `busy` is high during it. A low `ce_n` sampled in this window sets `ce_early` on the next cycle and starts no chip-enable refresh.
- R7: A falling `ce_n` outside self refresh and lockout gives one `row_pulse` on the next cycle, with `row_addr` equal to `ext_row`. The row counter is left unchanged.
- R8: A strobe-driven refresh is issued only after `ce_n` has been sampled high for CE_TO_REF consecutive cycles. Until then it is held back, and it is issued later.
- R9: If a chip-enable refresh and a held strobe refresh fall on the same cycle, the external row is refreshed first. The strobe refresh is kept and follows later.
- R10: The row counter wraps from 2^ROW_W-1 (511) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| rfsh_n | input | 1 | Active-low refresh strobe |
| ext_row | input | ROW_W | External row address for chip-enable-only refresh |
| row_addr | output | ROW_W | Row address of the latest refresh |
| row_pulse | output | 1 | One-cycle pulse per row refresh |
| busy | output | 1 | Refresh activity in progress or pending |
| ce_early | output | 1 | Chip enable seen during the post-self-refresh lockout |

## Verification
A chip-enable-only refresh and a held strobe-driven refresh can both want the same cycle. The bench provokes this by letting an auto-refresh pulse rise and then dropping `ce_n` exactly in the cycle when the held refresh would issue. The outcome is judged from the logged pulse sequence: the external row must come first, the counter row must follow only after the chip-enable guard time, and no refresh may be lost.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_RECOV = 3'd2,
    ST_SELF  = 3'd3,
    ST_EXIT  = 3'd4
  } psr_state_e;

endpackage

// File: rtl/psr_ce_track.sv
module psr_ce_track #(
  parameter int CE_TO_REF = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic ce_fall,
  output logic ce_ok
);

  localparam int CW = $clog2(CE_TO_REF + 1);

  logic          ce_q;
  logic [CW-1:0] hi_q, hi_d;

  always_comb begin
    if (ce_n) begin
      hi_d = (hi_q >= CW'(CE_TO_REF)) ? hi_q : hi_q + CW'(1);
    end else begin
      hi_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      hi_q <= CW'(CE_TO_REF);
    end else begin
      ce_q <= ce_n;
      hi_q <= hi_d;
    end
  end

  assign ce_fall = ce_q & ~ce_n;
  assign ce_ok   = (hi_q >= CW'(CE_TO_REF));

  AST_FALL_CLEARS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> !ce_ok); // R8

endmodule

// File: rtl/psr_row_ctr.sv
module psr_row_ctr #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] ctr
);

  logic [ROW_W-1:0] ctr_q, ctr_d;

  always_comb begin
    ctr_d = ctr_q;
    if (inc) ctr_d = ctr_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

  assign ctr = ctr_q;

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_q != $past(ctr_q)) |-> (ctr_q == $past(ctr_q) + ROW_W'(1))); // R10

endmodule

// File: rtl/psr_strobe_fsm.sv
module psr_strobe_fsm
  import psr_pkg::*;
#(
  parameter int MIN_PULSE   = 4,
  parameter int SELF_ENTRY  = 1000,
  parameter int SELF_PERIOD = 1953,
  parameter int RECOV_HIGH  = 4,
  parameter int CE_LOCKOUT  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rfsh_n,
  input  logic       ce_n,
  output psr_state_e state,
  output logic       ref_req,
  output logic       ce_early
);

  localparam int M1      = (SELF_ENTRY > CE_LOCKOUT) ? SELF_ENTRY : CE_LOCKOUT;
  localparam int M2      = (RECOV_HIGH > MIN_PULSE) ? RECOV_HIGH : MIN_PULSE;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TMR_W   = $clog2(SELF_PERIOD);

  psr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             early_q, early_d;
  logic             req;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tmr_d   = tmr_q;
    req     = 1'b0;
    early_d = (state_q == ST_EXIT) && !ce_n;
    case (state_q)
      ST_IDLE: begin
        if (!rfsh_n) begin
          state_d = ST_LOW;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_LOW: begin
        if (!rfsh_n) begin
          if ((cnt_q + CNT_W'(1)) >= CNT_W'(SELF_ENTRY)) begin
            state_d = ST_SELF;
            cnt_d   = '0;
            tmr_d   = '0;
            req     = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end else if (cnt_q >= CNT_W'(MIN_PULSE)) begin
          state_d = ST_RECOV;
          cnt_d   = CNT_W'(1);
          req     = 1'b1;
        end else begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      ST_RECOV: begin
        if (!rfsh_n) begin
          cnt_d = '0;
        end else if ((cnt_q + CNT_W'(1)) >= CNT_W'(RECOV_HIGH)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_SELF: begin
        if (rfsh_n) begin
          state_d = ST_EXIT;
          cnt_d   = CNT_W'(1);
        end else if (tmr_q == TMR_W'(SELF_PERIOD - 1)) begin
          tmr_d = '0;
          req   = 1'b1;
        end else begin
          tmr_d = tmr_q + TMR_W'(1);
        end
      end
      ST_EXIT: begin
        if (cnt_q >= CNT_W'(CE_LOCKOUT)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tmr_q   <= '0;
      early_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tmr_q   <= tmr_d;
      early_q <= early_d;
    end
  end

  assign state    = state_q;
  assign ref_req  = req;
  assign ce_early = early_q;

  AST_RECOV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV && !rfsh_n) |=> (state_q == ST_RECOV)); // R5
  AST_SELF_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELF && rfsh_n) |=> (state_q == ST_EXIT)); // R6
  AST_EARLY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    early_q |-> ($past(state_q) == ST_EXIT && !$past(ce_n))); // R6
  AST_SHORT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOW && rfsh_n && cnt_q < CNT_W'(MIN_PULSE)) |=> (state_q == ST_IDLE)); // R3

endmodule

// File: rtl/psram_refresh_seq.sv
module psram_refresh_seq
  import psr_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int MIN_PULSE   = 4,
  parameter int SELF_ENTRY  = 1000,
  parameter int SELF_PERIOD = 1953,
  parameter int RECOV_HIGH  = 4,
  parameter int CE_LOCKOUT  = 20,
  parameter int CE_TO_REF   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             rfsh_n,
  input  logic [ROW_W-1:0] ext_row,
  output logic [ROW_W-1:0] row_addr,
  output logic             row_pulse,
  output logic             busy,
  output logic             ce_early
);

  psr_state_e       state;
  logic             ref_req, ce_fall, ce_ok;
  logic             ce_ref, issue;
  logic [ROW_W-1:0] ctr;
  logic             pend_q, pend_d;
  logic             pulse_q, pulse_d;
  logic [ROW_W-1:0] addr_q, addr_d;

  psr_strobe_fsm #(
    .MIN_PULSE  (MIN_PULSE),
    .SELF_ENTRY (SELF_ENTRY),
    .SELF_PERIOD(SELF_PERIOD),
    .RECOV_HIGH (RECOV_HIGH),
    .CE_LOCKOUT (CE_LOCKOUT)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .rfsh_n  (rfsh_n),
    .ce_n    (ce_n),
    .state   (state),
    .ref_req (ref_req),
    .ce_early(ce_early)
  );

  psr_ce_track #(.CE_TO_REF(CE_TO_REF)) u_ce (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .ce_fall(ce_fall),
    .ce_ok  (ce_ok)
  );

  psr_row_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (issue),
    .ctr  (ctr)
  );

  always_comb begin
    ce_ref  = ce_fall && (state != ST_SELF) && (state != ST_EXIT);
    issue   = pend_q && ce_ok && ce_n;
    pend_d  = ref_req || (pend_q && !issue);
    pulse_d = ce_ref || issue;
    if (ce_ref)     addr_d = ext_row;
    else if (issue) addr_d = ctr;
    else            addr_d = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
      addr_q  <= addr_d;
    end
  end

  assign row_addr  = addr_q;
  assign row_pulse = pulse_q;
  assign busy      = (state != ST_IDLE) || pend_q;

  AST_STROBE_REF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !$past(ce_fall)) |-> ($past(ce_n) && $past(ce_ok))); // R8
  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ref && pend_q) |=> pend_q); // R9
  AST_CE_ROW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ce_ref |=> (row_pulse && row_addr == $past(ext_row))); // R7

endmodule

// File: tb/psram_refresh_seq_tb_top.sv
module psram_refresh_seq_tb_top;

  localparam int ROW_W = 9;
  localparam int NV    = 7;
  // low samples, high samples, expected refresh pulses
  localparam int VEC [NV][3] = '{
    '{4, 10, 1}, '{3, 10, 0}, '{1, 10, 0}, '{20, 10, 1},
    '{39, 10, 1}, '{5, 12, 1}, '{2, 10, 0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, ce_n, rfsh_n;
  logic [ROW_W-1:0] ext_row;
  logic [ROW_W-1:0] row_addr;
  logic             row_pulse, busy, ce_early;

  psram_refresh_seq #(
    .ROW_W(ROW_W), .MIN_PULSE(4), .SELF_ENTRY(40), .SELF_PERIOD(25),
    .RECOV_HIGH(4), .CE_LOCKOUT(20), .CE_TO_REF(7)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rfsh_n(rfsh_n), .ext_row(ext_row),
    .row_addr(row_addr), .row_pulse(row_pulse), .busy(busy), .ce_early(ce_early)
  );

  int n_chk = 0, n_fail = 0;
  int pulse_cnt = 0, early_cnt = 0;
  int exp_ctr = 0;
  int base, ebase;
  bit done = 1'b0;
  logic [ROW_W-1:0] rows [16];

  always @(posedge clk) begin
    #2;
    if (rst_n === 1'b1) begin
      if (row_pulse === 1'b1) begin
        rows[pulse_cnt % 16] = row_addr;
        pulse_cnt++;
      end
      if (ce_early === 1'b1) early_cnt++;
    end
  end

  function automatic int row_back(input int k);
    return int'(rows[(pulse_cnt - k) % 16]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int lo, input int hi);
    rfsh_n = 1'b0;
    repeat (lo) @(negedge clk);
    rfsh_n = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; rfsh_n = 1'b1; ext_row = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 row_addr", int'(row_addr), 0);
    chk("R1 row_pulse", int'(row_pulse), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ce_early", int'(ce_early), 0);

    // table of strobe lengths
    for (int i = 0; i < NV; i++) begin
      base = pulse_cnt;
      strobe(VEC[i][0], VEC[i][1]);
      chk($sformatf("R2/R3 vector %0d pulses", i), pulse_cnt - base, VEC[i][2]);
      if (VEC[i][2] > 0) begin
        chk($sformatf("R2 vector %0d row", i), row_back(1), exp_ctr);
        exp_ctr = (exp_ctr + 1) % 512;
      end
    end
    chk("R2 busy idle after table", int'(busy), 0);

    // R5 recovery: early low ignored, boundary accepted
    base = pulse_cnt;
    strobe(6, 1);
    strobe(6, 10);
    chk("R5 early low ignored", pulse_cnt - base, 1);
    exp_ctr = (exp_ctr + 1) % 512;
    base = pulse_cnt;
    strobe(6, 4);
    strobe(6, 10);
    chk("R5 boundary low accepted", pulse_cnt - base, 2);
    chk("R5 boundary row", row_back(1), (exp_ctr + 1) % 512);
    exp_ctr = (exp_ctr + 2) % 512;

    // R7 chip-enable-only refresh
    base = pulse_cnt;
    ext_row = 9'h105;
    ce_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 ce refresh pulse", pulse_cnt - base, 1);
    chk("R7 ce refresh row", row_back(1), 'h105);
    ce_n = 1'b1;
    ext_row = 9'h1FF;
    repeat (2) @(negedge clk);
    ce_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 ce refresh row max", row_back(1), 'h1FF);
    ce_n = 1'b1;
    repeat (10) @(negedge clk);
    strobe(5, 10);
    chk("R7 counter untouched", row_back(1), exp_ctr);
    exp_ctr = (exp_ctr + 1) % 512;

    // R8 strobe refresh deferred by recent chip enable
    base = pulse_cnt;
    ext_row = 9'h033;
    ce_n = 1'b0;
    rfsh_n = 1'b0;
    repeat (6) @(negedge clk);
    rfsh_n = 1'b1;
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 deferred not yet issued", pulse_cnt - base, 1);
    repeat (10) @(negedge clk);
    chk("R8 deferred issued later", pulse_cnt - base, 2);
    chk("R8 deferred row", row_back(1), exp_ctr);
    exp_ctr = (exp_ctr + 1) % 512;

    // R9 collision of chip-enable refresh and held strobe refresh
    base = pulse_cnt;
    ext_row = 9'h0AA;
    rfsh_n = 1'b0;
    repeat (6) @(negedge clk);
    rfsh_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    repeat (15) @(negedge clk);
    chk("R9 both refreshes kept", pulse_cnt - base, 2);
    chk("R9 external row first", row_back(2), 'h0AA);
    chk("R9 counter row second", row_back(1), exp_ctr);
    exp_ctr = (exp_ctr + 1) % 512;

    // R4 self refresh: 120 low samples -> entry + 3 timer refreshes
    base = pulse_cnt;
    ebase = early_cnt;
    rfsh_n = 1'b0;
    repeat (60) @(negedge clk);
    chk("R4 busy in self refresh", int'(busy), 1);
    repeat (60) @(negedge clk);
    rfsh_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 busy in lockout", int'(busy), 1);
    repeat (25) @(negedge clk);
    chk("R4 self refresh pulses", pulse_cnt - base, 4);
    for (int k = 0; k < 4; k++)
      chk($sformatf("R4 self row %0d", k), int'(rows[(base + k) % 16]), (exp_ctr + k) % 512);
    exp_ctr = (exp_ctr + 4) % 512;
    chk("R6 busy after lockout", int'(busy), 0);
    chk("R6 no early flag", early_cnt - ebase, 0);

    // R6 early chip enable inside lockout
    base = pulse_cnt;
    ebase = early_cnt;
    strobe(50, 5);
    ce_n = 1'b0;
    repeat (25) @(negedge clk);
    ce_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 early flag raised", (early_cnt > ebase) ? 1 : 0, 1);
    chk("R6 no ce refresh in lockout", pulse_cnt - base, 1);
    exp_ctr = (exp_ctr + 1) % 512;

    // R6 chip enable after lockout is a normal refresh
    base = pulse_cnt;
    ebase = early_cnt;
    ext_row = 9'h0F0;
    strobe(50, 25);
    ce_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 late ce refresh", pulse_cnt - base, 2);
    chk("R6 late ce row", row_back(1), 'h0F0);
    chk("R6 late ce no flag", early_cnt - ebase, 0);
    ce_n = 1'b1;
    exp_ctr = (exp_ctr + 1) % 512;
    repeat (10) @(negedge clk);

    // R10 counter wrap
    while (exp_ctr != 0) begin
      strobe(4, 7);
      if (exp_ctr == 511) chk("R10 row before wrap", row_back(1), 511);
      exp_ctr = (exp_ctr + 1) % 512;
    end
    strobe(4, 7);
    chk("R10 row after wrap", row_back(1), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule